// File: doc/BRIEF.md
# Data Bus Request Rule Monitor

This block watches the request side of a processor's data memory port and judges every cycle in which a request is offered. It checks the byte-enable lanes and the low address bits that go with them. Three rules are checked. At least one lane must be enabled. The enabled lanes must form a single unbroken run. The address offset inside the word must not point above the lowest enabled lane. A fourth rule covers a request that is waiting for a grant: its address, lane mask and direction must not change while it waits.

Each rule drives its own one-cycle pulse, one clock after the offending cycle. Any violation also sets a flag that stays set until reset. A counter records how many cycles broke at least one rule, and it stops at its largest value instead of wrapping. The monitor does not look at responses, arbitration or memory contents. It can be left in a design as a permanent on-chip rule checker, or it can be used inside a bench.

Top module: `bus_addr_phase_monitor`

## Requirements
- R1: A cycle with `req`=1 and `be`=4'b0000 raises `emptyBePulse` for exactly the next clock cycle.
- R2: A cycle with `req`=1 whose nonzero `be` has its set bits in two or more separate groups (for example 4'b1010, 4'b1001, 4'b0101) raises `gapBePulse` in the next cycle.
- R3: With `req`=1 and `be` nonzero, let k be the bit index of the lowest set bit of `be`. If `addr[1:0]` > k, `misalignPulse` is raised in the next cycle. An all-zero `be` never raises `misalignPulse`.
- R4: A cycle that breaks no rule raises no pulse in the next cycle. This includes `addr[1:0]`=3 with `be`=4'b1000 and `addr[1:0]`=0 with `be`=4'b1111. A cycle with `req`=0 raises no pulse, whatever `addr`, `be` and `we` hold.
- R5: The rules in R1 to R3 are judged in every cycle that `req` is high, including each cycle a request spends waiting for `gnt`.
- R6: If the previous cycle had `req`=1 and `gnt`=0, and the current cycle has `req`=1 with a different `addr`, `be` or `we`, then `unstablePulse` is raised in the next cycle.
- R7: `errSticky` goes to 1 in the same cycle as the first violation pulse and then stays at 1 until reset.
- R8: `violCount` increments by one for each cycle that breaks at least one rule. It holds at 16'hFFFF once it reaches that value.
- R9: Reset is synchronous and active low (`rstN`). A clock edge with `rstN`=0 clears every pulse, `errSticky`, `violCount` and the pending-request history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request offered in this cycle |
| gnt | input | 1 | Request accepted in this cycle |
| addr | input | 32 | Request address |
| be | input | 4 | Byte-lane enables |
| we | input | 1 | Write when 1, read when 0 |
| errSticky | output | 1 | Set by any violation, cleared only by reset |
| emptyBePulse | output | 1 | No lane enabled (R1) |
| gapBePulse | output | 1 | Enabled lanes not contiguous (R2) |
| misalignPulse | output | 1 | Address offset above lowest enabled lane (R3) |
| unstablePulse | output | 1 | Request changed while waiting for grant (R6) |
| violCount | output | 16 | Saturating count of violating cycles |

## Verification
The properties assume that `req`, `gnt`, `addr`, `be` and `we` carry known 0/1 values at every rising edge after reset. They also assume that `rstN` is held low for at least one edge before checking begins. The stimulus changes inputs only on falling edges and drives only 0 or 1. Stimulus includes long stretches of waiting requests, deliberate changes while a request waits, and a long run of violations that drives the counter into saturation. All of this stays inside those assumptions, so any property failure points to the monitor itself.

// File: rtl/apmon_pkg.sv
package apmon_pkg;
  typedef struct packed {
    logic emptyBe;
    logic gapBe;
    logic misalign;
    logic unstable;
  } ruleHits_t;
endpackage

// File: rtl/apmon_ctrl.sv
module apmon_ctrl
  import apmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic              we,
  input  logic              pending,
  input  logic [ADDR_W-1:0] prevAddr,
  input  logic [BE_W-1:0]   prevBe,
  input  logic              prevWe,
  output ruleHits_t         hits
);
  localparam int LSB_W = $clog2(BE_W);

  logic [LSB_W-1:0] lowIdx;
  int               runStarts;
  logic             anyLane;

  // lowest enabled lane: scan from the top so the last hit wins
  always_comb begin
    lowIdx = '0;
    for (int k = BE_W - 1; k >= 0; k--) begin
      if (be[k]) lowIdx = LSB_W'(k);
    end
  end

  // count the places where a run of enabled lanes begins
  always_comb begin
    runStarts = be[0] ? 1 : 0;
    for (int k = 1; k < BE_W; k++) begin
      if (be[k] && !be[k-1]) runStarts = runStarts + 1;
    end
  end

  assign anyLane = |be;

  always_comb begin
    hits          = '0;
    hits.emptyBe  = req && !anyLane;
    hits.gapBe    = req && (runStarts > 1);
    hits.misalign = req && anyLane && (addr[LSB_W-1:0] > lowIdx);
    hits.unstable = req && pending &&
                    ((addr != prevAddr) || (be != prevBe) || (we != prevWe));
  end
endmodule

// File: rtl/apmon_dp.sv
module apmon_dp
  import apmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ruleHits_t         hits,
  input  logic              req,
  input  logic              gnt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic              we,
  output ruleHits_t         pulses,
  output logic              errSticky,
  output logic [CNT_W-1:0]  violCount,
  output logic              pending,
  output logic [ADDR_W-1:0] prevAddr,
  output logic [BE_W-1:0]   prevBe,
  output logic              prevWe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic anyHit;
  assign anyHit = |hits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulses    <= '0;
      errSticky <= 1'b0;
      violCount <= '0;
    end else begin
      pulses <= hits;
      if (anyHit) errSticky <= 1'b1;
      if (anyHit && (violCount != CNT_MAX)) violCount <= violCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      prevAddr <= '0;
      prevBe   <= '0;
      prevWe   <= 1'b0;
    end else begin
      pending <= req && !gnt;
      if (req) begin
        prevAddr <= addr;
        prevBe   <= be;
        prevWe   <= we;
      end
    end
  end
endmodule

// File: rtl/bus_addr_phase_monitor.sv
module bus_addr_phase_monitor
  import apmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              gnt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic              we,
  output logic              errSticky,
  output logic              emptyBePulse,
  output logic              gapBePulse,
  output logic              misalignPulse,
  output logic              unstablePulse,
  output logic [CNT_W-1:0]  violCount
);
  ruleHits_t         hits;
  ruleHits_t         pulses;
  logic              pending;
  logic [ADDR_W-1:0] prevAddr;
  logic [BE_W-1:0]   prevBe;
  logic              prevWe;

  apmon_ctrl #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_ctrl (
    .req(req), .addr(addr), .be(be), .we(we),
    .pending(pending), .prevAddr(prevAddr), .prevBe(prevBe), .prevWe(prevWe),
    .hits(hits)
  );

  apmon_dp #(.ADDR_W(ADDR_W), .BE_W(BE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .hits(hits),
    .req(req), .gnt(gnt), .addr(addr), .be(be), .we(we),
    .pulses(pulses), .errSticky(errSticky), .violCount(violCount),
    .pending(pending), .prevAddr(prevAddr), .prevBe(prevBe), .prevWe(prevWe)
  );

  assign emptyBePulse  = pulses.emptyBe;
  assign gapBePulse    = pulses.gapBe;
  assign misalignPulse = pulses.misalign;
  assign unstablePulse = pulses.unstable;
endmodule

// File: rtl/apmon_checker.sv
module apmon_checker #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              gnt,
  input logic [ADDR_W-1:0] addr,
  input logic [BE_W-1:0]   be,
  input logic              we,
  input logic              errSticky,
  input logic              emptyBePulse,
  input logic              gapBePulse,
  input logic              misalignPulse,
  input logic              unstablePulse,
  input logic [CNT_W-1:0]  violCount
);
  localparam int LSB_W = $clog2(BE_W);
  localparam logic [BE_W-1:0]  TOP_LANE = {1'b1, {(BE_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic anyPulse;
  assign anyPulse = emptyBePulse | gapBePulse | misalignPulse | unstablePulse;

  p_empty_flag_r1: assert property (@(posedge clk) disable iff (!rstN)
    (req && be == '0) |=> emptyBePulse);

  p_no_misalign_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (be == '0) |=> !misalignPulse);

  p_top_lane_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (req && be == TOP_LANE && addr[LSB_W-1:0] == '1) |=>
      !(emptyBePulse || gapBePulse || misalignPulse));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !req |=> !anyPulse);

  p_wait_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    (req && !gnt) ##1 (req && !$stable(be)) |=> unstablePulse);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  p_pulse_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |-> errSticky);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (violCount == $past(violCount)) || (violCount == $past(violCount) + 1'b1));

  p_count_sat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (violCount == CNT_MAX) |=> (violCount == CNT_MAX));
endmodule

bind bus_addr_phase_monitor apmon_checker #(
  .ADDR_W(ADDR_W), .BE_W(BE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .req(req), .gnt(gnt), .addr(addr), .be(be), .we(we),
  .errSticky(errSticky), .emptyBePulse(emptyBePulse), .gapBePulse(gapBePulse),
  .misalignPulse(misalignPulse), .unstablePulse(unstablePulse), .violCount(violCount)
);

// File: tb/test_bus_addr_phase_monitor.sv
`timescale 1ns/1ps
module test_bus_addr_phase_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0, gnt = 1'b0, we = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  be = '0;
  logic        errSticky, emptyBePulse, gapBePulse, misalignPulse, unstablePulse;
  logic [15:0] violCount;

  always #2.5 clk = ~clk;

  bus_addr_phase_monitor i_bus_addr_phase_monitor (
    .clk(clk), .rstN(rstN), .req(req), .gnt(gnt), .addr(addr), .be(be), .we(we),
    .errSticky(errSticky), .emptyBePulse(emptyBePulse), .gapBePulse(gapBePulse),
    .misalignPulse(misalignPulse), .unstablePulse(unstablePulse), .violCount(violCount)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // reference state
  bit          mPend = 0, mPrevWe = 0;
  logic [31:0] mPrevAddr = '0;
  logic [3:0]  mPrevBe = '0;
  bit          eEmpty = 0, eGap = 0, eMis = 0, eUns = 0, eSticky = 0;
  int          eCount = 0;

  function automatic int lowLane(logic [3:0] b);
    int i = 0;
    while (i < 4 && !b[i]) i++;
    return i;
  endfunction

  function automatic bit isRun(logic [3:0] b);
    int lo = lowLane(b);
    int ones = $countones(b);
    return ((b >> lo) == ((1 << ones) - 1));
  endfunction

  task automatic model();
    if (!rstN) begin
      {eEmpty, eGap, eMis, eUns, eSticky} = '0;
      eCount = 0; mPend = 0; mPrevAddr = '0; mPrevBe = '0; mPrevWe = 0;
    end else begin
      eEmpty = req && (be == 0);
      eGap   = req && (be != 0) && !isRun(be);
      eMis   = req && (be != 0) && (int'(addr[1:0]) > lowLane(be));
      eUns   = req && mPend && (addr != mPrevAddr || be != mPrevBe || we != mPrevWe);
      if (eEmpty || eGap || eMis || eUns) begin
        eSticky = 1;
        if (eCount < 65535) eCount++;
      end
      mPend = req && !gnt;
      if (req) begin mPrevAddr = addr; mPrevBe = be; mPrevWe = we; end
    end
  endtask

  task automatic chk(bit act, bit exp, string rq, string tag);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (%s): actual %0b expected %0b", rq, tag, act, exp);
    end
  endtask

  task automatic cycle(bit r, bit g, logic [31:0] a, logic [3:0] b, bit w, string tag);
    @(negedge clk);
    req = r; gnt = g; addr = a; be = b; we = w;
    model();
    @(posedge clk); #1;
    vectors++;
    chk(emptyBePulse,  eEmpty,  "R1", tag);
    chk(gapBePulse,    eGap,    "R2", tag);
    chk(misalignPulse, eMis,    "R3", tag);
    chk(unstablePulse, eUns,    "R6", tag);
    chk(errSticky,     eSticky, "R7", tag);
    if (violCount !== 16'(eCount)) begin
      miscompares++;
      $display("FAIL R8 (%s): actual %0d expected %0d", tag, violCount, eCount);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R9: reset with violating inputs present
    rstN = 0;
    cycle(1, 0, 32'h3, 4'b0000, 0, "R9 reset");
    cycle(1, 0, 32'h1, 4'b1010, 1, "R9 reset");
    rstN = 1;
    // R4: legal patterns, idle with junk
    cycle(1, 1, 32'h3, 4'b1000, 1, "R4 top lane at 3");
    cycle(1, 1, 32'h0, 4'b1111, 0, "R4 full word");
    cycle(1, 1, 32'h2, 4'b1100, 0, "R4 half");
    cycle(0, 0, 32'h3, 4'b0000, 1, "R4 idle");
    cycle(0, 1, 32'h1, 4'b1001, 0, "R4 idle");
    // R1, R2, R3 single cycles
    cycle(1, 1, 32'h0, 4'b0000, 1, "R1 empty");
    cycle(1, 1, 32'h0, 4'b1010, 0, "R2 gap");
    cycle(1, 1, 32'h0, 4'b1001, 0, "R2 gap ends");
    cycle(1, 1, 32'h3, 4'b0001, 1, "R3 addr3 lane0");
    cycle(1, 1, 32'h2, 4'b0110, 1, "R3 addr2 lane1");
    cycle(1, 1, 32'h3, 4'b0000, 0, "R3 empty no misalign");
    // R5: waiting request checked every cycle
    cycle(1, 0, 32'h1, 4'b0101, 0, "R5 wait1");
    cycle(1, 0, 32'h1, 4'b0101, 0, "R5 wait2");
    cycle(1, 1, 32'h1, 4'b0101, 0, "R5 grant");
    // R6: changes while waiting
    cycle(1, 0, 32'h10, 4'b1111, 1, "R6 start");
    cycle(1, 0, 32'h14, 4'b1111, 1, "R6 addr change");
    cycle(1, 0, 32'h14, 4'b0011, 1, "R6 be change");
    cycle(1, 0, 32'h14, 4'b0011, 0, "R6 we change");
    cycle(1, 1, 32'h14, 4'b0011, 0, "R6 held grant");
    cycle(1, 0, 32'h20, 4'b1111, 0, "R6 new after grant");
    cycle(0, 0, 32'h24, 4'b1111, 0, "R6 dropped");
    cycle(1, 0, 32'h28, 4'b1111, 0, "R6 fresh");
    // R9 mid-run reset clears sticky and counter
    rstN = 0;
    cycle(1, 0, 32'h3, 4'b0001, 0, "R9 mid reset");
    rstN = 1;
    cycle(1, 0, 32'h7, 4'b0001, 0, "R9 history cleared");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit r = ($urandom % 4) != 0;
      bit g = $urandom % 2;
      logic [31:0] a = ($urandom % 3 == 0) ? $urandom : addr;
      logic [3:0]  b = ($urandom % 3 == 0) ? 4'($urandom) : be;
      bit w = ($urandom % 5 == 0) ? ~we : we;
      cycle(r, g, a, b, w, "random");
    end
    // R8: saturation
    for (int n = 0; n < 65600; n++) cycle(1, 1, 32'h0, 4'b0000, 0, "R8 saturate");
    cycle(1, 1, 32'h0, 4'b1111, 0, "R8 hold max");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule